// File: doc/BRIEF.md
# Timer Clock Prescaler with Synchronized Halt

This block produces the count-enable pulse for an 8-bit timer. It picks a time base and runs a 14-bit free-running divider on it. A 4-bit select field then chooses which divided rate reaches the timer as a one-cycle enable pulse. The time base is either every system clock or an external tick-enable that marks fast peripheral clock events. The select field can also stop the timer. Everything runs in one clock domain.

Software controls the block through two control bits. Each write strobe loads both of them. The divider-clear bit zeroes the divider and normally drops by itself on the next clock. When the hold bit is also set, the clear stays in force, so the timer receives no pulses and can be reconfigured safely. When software writes the hold bit back to 0, the clear is released in hardware. Counting then resumes from zero, and the first pulse arrives exactly one selected period later.

Top module: `tmr_prescaler`

## Requirements
- R1: After a synchronous reset, `ctl_sync`, `ctl_rst` and `cnt_en` are all 0.
- R2: With `fast_sel` = 0 the divider advances on every clock. With `fast_sel` = 1 it advances only in cycles where `fast_tick` = 1, and no pulse is issued in a cycle without a tick.
- R3: `clk_sel` encoding. Value 0 means stop (no pulses). Value 1 gives a pulse for every base tick. Value k from 2 to 15 gives one pulse per 2^(k-1) base ticks. `cnt_en` is a registered one-cycle pulse, high the clock after the qualifying tick.
- R4: A write (`wr_en` = 1) loads `ctl_sync` from `wr_sync` and `ctl_rst` from `wr_rst`. While `ctl_rst` is 1 the divider is forced to zero. With `ctl_sync` = 0, `ctl_rst` returns to 0 one clock later, so the first pulse comes 2^(k-1)+1 clocks after the write edge (system clock base).
- R5: No `cnt_en` pulse occurs in the clock that follows any cycle with `ctl_rst` = 1.
- R6: While `ctl_sync` = 1 and no write occurs, `ctl_rst` keeps its value.
- R7: Writing `wr_sync` = 0 with `wr_rst` = 0 clears both bits at that edge. The first pulse then arrives 2^(k-1) clocks after the write edge (system clock base).
- R8: A change of `clk_sel` leaves the divider running. The next pulse comes from the current divider value, not from a restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock |
| rst | input | 1 | Synchronous active-high reset |
| fast_sel | input | 1 | Time base: 0 = system clock, 1 = fast tick |
| fast_tick | input | 1 | Fast peripheral clock tick-enable |
| clk_sel | input | 4 | Rate select: stop, undivided or divided by 2^(k-1) |
| wr_en | input | 1 | Control write strobe |
| wr_sync | input | 1 | Write data for the hold bit |
| wr_rst | input | 1 | Write data for the divider-clear bit |
| ctl_sync | output | 1 | Current hold bit |
| ctl_rst | output | 1 | Current divider-clear bit |
| cnt_en | output | 1 | Registered count-enable pulse to the timer |

## Verification
The assertions check on every cycle that the clear bit zeroes the divider and blocks the next pulse. They also check that the clear bit drops by itself only without the hold bit and stays set while the hold bit is set. Finally they check that stop and undivided codes give the right next-cycle output and that the divider freezes on missing fast ticks. Pulse spacing for each select code, the exact delay to the first pulse after a clear or a hold release, and the effect of a select change in mid-count need long sequences. Only the bench's scenarios, checked against its cycle model, can show these.

// File: rtl/tps_pkg.sv
package tps_pkg;
  localparam int DEF_DIV_W = 14;
  localparam int SEL_STOP  = 0;
  localparam int SEL_DIRECT = 1;
endpackage

// File: rtl/tps_ctl.sv
module tps_ctl (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic wr_sync,
  input  logic wr_rst,
  output logic sync_q,
  output logic prst_q
);
  // R4 R6 R7: write loads both bits; clear self-drops only without hold
  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= 1'b0;
      prst_q <= 1'b0;
    end else if (wr_en) begin
      sync_q <= wr_sync;
      prst_q <= wr_rst;
    end else if (!sync_q) begin
      prst_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tps_divider.sv
module tps_divider #(
  parameter int DIV_W = tps_pkg::DEF_DIV_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             base_tick,
  output logic [DIV_W-1:0] div_cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr)     div_cnt <= '0;
    else if (base_tick) div_cnt <= div_cnt + 1'b1;
  end
endmodule

// File: rtl/tps_tapsel.sv
module tps_tapsel #(
  parameter int DIV_W = tps_pkg::DEF_DIV_W,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             base_tick,
  input  logic [DIV_W-1:0] div_cnt,
  input  logic [SEL_W-1:0] clk_sel,
  output logic             en_q
);
  localparam int NTAP = DIV_W + 1;
  localparam int NSEL = 1 << SEL_W;

  logic [NTAP-1:0] tap;
  logic [NSEL-1:0] sel_vec;

  // tap n fires on the tick that completes 2^n base ticks
  for (genvar n = 0; n < NTAP; n++) begin : g_tap
    if (n == 0) begin : g_t0
      assign tap[n] = base_tick;
    end else begin : g_tn
      assign tap[n] = base_tick & (&div_cnt[n-1:0]);
    end
  end

  // R3: code 0 stop, code k picks tap k-1
  for (genvar k = 0; k < NSEL; k++) begin : g_sel
    if (k == tps_pkg::SEL_STOP || (k - 1) > DIV_W) begin : g_off
      assign sel_vec[k] = 1'b0;
    end else begin : g_on
      assign sel_vec[k] = tap[k-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b0;
    else     en_q <= !clr && sel_vec[clk_sel];
  end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int DIV_W = tps_pkg::DEF_DIV_W,
  parameter int SEL_W = $clog2(DIV_W + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fast_sel,
  input  logic             fast_tick,
  input  logic [SEL_W-1:0] clk_sel,
  input  logic             wr_en,
  input  logic             wr_sync,
  input  logic             wr_rst,
  output logic             ctl_sync,
  output logic             ctl_rst,
  output logic             cnt_en
);
  logic             base_tick;
  logic [DIV_W-1:0] div_cnt;

  // R2: system clock base is an always-active tick
  assign base_tick = fast_sel ? fast_tick : 1'b1;

  tps_ctl u_ctl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sync(wr_sync),
    .wr_rst(wr_rst), .sync_q(ctl_sync), .prst_q(ctl_rst)
  );

  tps_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .clr(ctl_rst), .base_tick(base_tick),
    .div_cnt(div_cnt)
  );

  tps_tapsel #(.DIV_W(DIV_W), .SEL_W(SEL_W)) u_sel (
    .clk(clk), .rst(rst), .clr(ctl_rst), .base_tick(base_tick),
    .div_cnt(div_cnt), .clk_sel(clk_sel), .en_q(cnt_en)
  );
endmodule

// File: rtl/tmr_prescaler_chk.sv
module tmr_prescaler_chk #(
  parameter int DIV_W = 14,
  parameter int SEL_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             fast_sel,
  input logic             fast_tick,
  input logic [SEL_W-1:0] clk_sel,
  input logic             wr_en,
  input logic             wr_sync,
  input logic             wr_rst,
  input logic             ctl_sync,
  input logic             ctl_rst,
  input logic             cnt_en,
  input logic [DIV_W-1:0] div_cnt
);
  AST_CLEAR_ZEROES_DIV: assert property (@(posedge clk) disable iff (rst)
    ctl_rst |=> div_cnt == '0); // R4
  AST_CLEAR_SELF_DROPS: assert property (@(posedge clk) disable iff (rst)
    ctl_rst && !ctl_sync && !wr_en |=> !ctl_rst); // R4
  AST_QUIET_IN_CLEAR: assert property (@(posedge clk) disable iff (rst)
    ctl_rst |=> !cnt_en); // R5
  AST_HOLD_KEEPS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    ctl_sync && ctl_rst && !wr_en |=> ctl_rst && ctl_sync); // R6
  AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    wr_en && !wr_sync && !wr_rst |=> !ctl_rst && !ctl_sync); // R7
  AST_STOP_CODE: assert property (@(posedge clk) disable iff (rst)
    clk_sel == '0 |=> !cnt_en); // R3
  AST_DIRECT_CODE: assert property (@(posedge clk) disable iff (rst)
    clk_sel == SEL_W'(1) && !ctl_rst && !fast_sel |=> cnt_en); // R3
  AST_FAST_IDLE: assert property (@(posedge clk) disable iff (rst)
    fast_sel && !fast_tick && !ctl_rst |=> $stable(div_cnt) && !cnt_en); // R2
endmodule

bind tmr_prescaler tmr_prescaler_chk #(.DIV_W(DIV_W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst(rst), .fast_sel(fast_sel), .fast_tick(fast_tick),
  .clk_sel(clk_sel), .wr_en(wr_en), .wr_sync(wr_sync), .wr_rst(wr_rst),
  .ctl_sync(ctl_sync), .ctl_rst(ctl_rst), .cnt_en(cnt_en), .div_cnt(div_cnt)
);

// File: tb/tb_tmr_prescaler.sv
module tb_tmr_prescaler;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fast_sel = 1'b0, fast_tick = 1'b0;
  logic [3:0] clk_sel = 4'd0;
  logic wr_en = 1'b0, wr_sync = 1'b0, wr_rst = 1'b0;
  logic ctl_sync, ctl_rst, cnt_en;

  int total = 0, bad = 0, cyc = 0;
  bit fast_run = 1'b0, done = 1'b0;
  int tick_div = 3, tcnt = 0;
  string cur_req = "R1";

  // reference model state
  bit m_sync, m_prst, m_en;
  int m_cnt;

  always #10 clk = ~clk; // 50 MHz

  tmr_prescaler dut (
    .clk(clk), .rst(rst), .fast_sel(fast_sel), .fast_tick(fast_tick),
    .clk_sel(clk_sel), .wr_en(wr_en), .wr_sync(wr_sync), .wr_rst(wr_rst),
    .ctl_sync(ctl_sync), .ctl_rst(ctl_rst), .cnt_en(cnt_en)
  );

  function automatic bit model_hit(int code, int cnt);
    if (code == 0) return 1'b0;
    return ((cnt + 1) % (1 << (code - 1))) == 0;
  endfunction

  always @(posedge clk) begin
    bit tk;
    if (rst) begin
      m_sync <= 0; m_prst <= 0; m_cnt <= 0; m_en <= 0;
    end else begin
      tk = fast_sel ? fast_tick : 1'b1;
      m_en  <= !m_prst && tk && model_hit(int'(clk_sel), m_cnt);
      m_cnt <= m_prst ? 0 : (tk ? (m_cnt + 1) % 16384 : m_cnt);
      if (wr_en) begin m_sync <= wr_sync; m_prst <= wr_rst; end
      else if (!m_sync) m_prst <= 0;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(cur_req, "model cnt_en", cnt_en, m_en);
      check(cur_req, "model ctl_rst", ctl_rst, m_prst);
      check(cur_req, "model ctl_sync", ctl_sync, m_sync);
    end
  end

  // fast tick generator
  always @(negedge clk) begin
    if (fast_run) begin
      fast_tick <= (tcnt % tick_div) == 0;
      tcnt <= tcnt + 1;
    end else begin
      fast_tick <= 1'b0;
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 190000);
      finish_run();
    end
  end

  task automatic write_ctl(bit s, bit r);
    @(negedge clk);
    wr_en = 1'b1; wr_sync = s; wr_rst = r;
    @(negedge clk);
    wr_en = 1'b0; wr_sync = 1'b0; wr_rst = 1'b0;
  endtask

  // negedges until a pulse is seen, 1 = right after the next edge
  task automatic wait_pulse(int lim, output int n);
    n = 0;
    while (n < lim) begin
      @(negedge clk);
      n++;
      if (cnt_en) return;
    end
    n = -1;
  endtask

  task automatic count_pulses(int len, output int c);
    c = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (cnt_en) c++;
    end
  endtask

  initial begin
    int n, c, p;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check("R1", "ctl_sync after reset", ctl_sync, 0);
    check("R1", "ctl_rst after reset", ctl_rst, 0);
    check("R1", "cnt_en after reset", cnt_en, 0);

    // R3 stop code
    cur_req = "R3";
    clk_sel = 4'd0;
    count_pulses(100, c);
    check("R3", "pulses with stop code", c, 0);

    // R3 and R4: spacing and first pulse for every code
    for (int k = 1; k < 16; k++) begin
      p = 1 << (k - 1);
      cur_req = "R4";
      clk_sel = 4'(k);
      write_ctl(1'b0, 1'b1);
      wait_pulse(p + 10, n);
      check("R4", $sformatf("first pulse code %0d", k), n, p + 1);
      cur_req = "R3";
      wait_pulse(p + 10, n);
      check("R3", $sformatf("spacing code %0d", k), n, p);
    end

    // R5 and R6: hold in sync mode
    cur_req = "R6";
    clk_sel = 4'd4;
    write_ctl(1'b1, 1'b1);
    count_pulses(200, c);
    check("R5", "pulses while held", c, 0);
    check("R6", "ctl_rst while held", ctl_rst, 1);
    check("R6", "ctl_sync while held", ctl_sync, 1);

    // R7: release
    cur_req = "R7";
    write_ctl(1'b0, 1'b0);
    check("R7", "ctl_rst after release", ctl_rst, 0);
    wait_pulse(30, n);
    check("R7", "first pulse after release code 4", n, 8);

    // R8: select change keeps divider running
    cur_req = "R8";
    clk_sel = 4'd6;
    write_ctl(1'b0, 1'b1);
    repeat (10) @(negedge clk);
    clk_sel = 4'd3;
    wait_pulse(20, n);
    check("R8", "next pulse after select change", n, 3);

    // R2: fast tick base, one tick every 3 clocks, code 3 -> 12 clocks
    cur_req = "R2";
    fast_run = 1'b1;
    fast_sel = 1'b1;
    write_ctl(1'b0, 1'b1);
    wait_pulse(60, n);
    check("R2", "fast base pulse seen", int'(n > 0), 1);
    wait_pulse(60, n);
    check("R2", "fast base spacing code 3", n, 12);
    clk_sel = 4'd1;
    wait_pulse(10, n);
    wait_pulse(10, n);
    check("R2", "fast base spacing code 1", n, 3);
    fast_sel = 1'b0;
    fast_run = 1'b0;
    repeat (4) @(negedge clk);

    finish_run();
  end
endmodule